// File: doc/BRIEF.md
# Serial Transmitter with Line Control

This block turns bytes into asynchronous serial frames on one output pin. A host writes bytes and configuration through a small write-only register bus. One control byte sets the frame format: how many data bits (5 to 8), one or two stop bits, whether a parity bit is sent and what kind, and a forced break. A 16-bit divisor sets the bit rate. A tick is produced once every `divisor` clocks, and each bit on the line lasts 16 ticks.

A byte goes first into a holding register. At the start of the next frame it moves into a shift register, and the holding register is free again. Two flags are driven on separate outputs. One reports that the holding register is empty. The other reports that the transmitter is empty, which means both the holding register and the shift register are idle. A host can therefore queue the next byte while the current one is still being sent, and frames go out back to back with no idle time between them.

Top module: `serial_tx_core`

## Requirements
- R1: After reset the line is high (`txOut`=1), `holdEmpty`=1, `txEmpty`=1, the control byte is 0 and the divisor is 0.
- R2: Register map. Address 2 writes the control byte. While control bit 7 (the bank bit) is 0, address 0 writes the holding register and address 1 is ignored. While the bank bit is 1, address 0 writes the divisor low byte and address 1 writes the divisor high byte. Address 3 is ignored.
- R3: A frame starts with a start bit of 0. The data bits follow, least significant bit first. Control bits 1:0 set the word length: 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits.
- R4: Control bit 3 enables a parity bit, sent after the data bits. When bit 5 (stick) is also 1, the parity bit is the inverse of bit 4. Otherwise, bit 4 = 1 selects even parity (ones in the data plus parity bit add up to an even count) and bit 4 = 0 selects odd parity.
- R5: Control bit 2 = 0 gives a stop length of 16 ticks. Bit 2 = 1 gives 32 ticks, or 24 ticks with a 5-bit word. The stop level is 1.
- R6: One tick is produced every `divisor` clocks and every start, data and parity bit lasts 16 ticks. A divisor of 0 produces no ticks, so nothing is transmitted.
- R7: A holding write clears `holdEmpty` on the next cycle. The byte moves into the shift register on a tick. In the same cycle `holdEmpty` sets and the start bit appears. If a byte is waiting at the last stop tick, the next start bit follows the stop bit with no idle time.
- R8: `txEmpty` is 1 only when the holding register is empty and no frame is in progress. It rises in the cycle after the last stop tick. The idle line is high.
- R9: While control bit 6 is 1, `txOut` is 0. The frame sequence and its timing continue unchanged underneath.
- R10: The word length, stop and parity settings are captured when a byte enters the shift register. A control write during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Register write data |
| txOut | output | 1 | Serial line output |
| holdEmpty | output | 1 | Holding register is empty |
| txEmpty | output | 1 | Holding and shift registers both idle |

## Verification
A bus write takes effect at the edge where it is sampled. With a divisor of 1, the start bit and `holdEmpty` rising follow a holding write by exactly one more edge. With a larger divisor they follow at the next tick. The bench therefore finds the first low sample of the line and measures everything else from that sample, counting clocks. Each bit is sampled in the middle of its cell, at 8 + 16k ticks. The end of a frame is pinned with two samples: `txEmpty` is 0 exactly one clock before frame length × divisor and 1 at that point. This also checks the stop length and that a mid-frame control write or break did not move the end of the frame. Back-to-back frames are checked the same way, by sampling the stop bit and then the next start bit in adjacent cycles.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  localparam int BYTE_W   = 8;
  localparam int DIV_W    = 2 * BYTE_W;
  localparam int ADDR_W   = 2;
  localparam int MIN_WORD = BYTE_W - 3;

  localparam logic [ADDR_W-1:0] ADDR_DATA  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIVHI = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_LINE  = 2'd2;

  // control byte, MSB first
  typedef struct packed {
    logic       bank;
    logic       brk;
    logic       stickSel;
    logic       evenSel;
    logic       parEn;
    logic       twoStop;
    logic [1:0] wordSel;
  } lineCtl_t;

  // frame format captured at load
  typedef struct packed {
    logic [1:0] wordSel;
    logic       twoStop;
    logic       parEn;
  } frameCfg_t;

  typedef enum logic [1:0] {
    OUT_MARK,
    OUT_SPACE,
    OUT_DATA,
    OUT_PARITY
  } outSel_t;

  // control to datapath strobes
  typedef struct packed {
    logic    load;
    logic    shift;
    outSel_t outSel;
  } txStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } txState_t;

endpackage

// File: rtl/serial_tx_baud.sv
module serial_tx_baud
  import serial_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             restart,
  output logic             tick
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic             running;
  logic             atLimit;

  assign running = (divisor != '0);
  assign atLimit = (cnt == divisor - ONE);
  assign tick    = running && !restart && atLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (restart || !running || atLimit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + ONE;
    end
  end

endmodule

// File: rtl/serial_tx_datapath.sv
module serial_tx_datapath
  import serial_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  input  txStrobe_t         strobe,
  output logic              holdFull,
  output frameCfg_t         frameCfg,
  output logic [DIV_W-1:0]  divisor,
  output logic              divWrite,
  output logic              breakOn,
  output logic              txOut
);

  lineCtl_t          lineCtl;
  logic [BYTE_W-1:0] holdReg;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] wordMask;
  logic              parBit;
  logic              parNext;
  logic              holdWr;
  logic              divLoWr;
  logic              divHiWr;
  logic              lineWr;
  logic              dataSel;

  // address decode, bank bit picks the second register set
  assign dataSel  = busWe && (busAddr == ADDR_DATA);
  assign holdWr   = dataSel && !lineCtl.bank;
  assign divLoWr  = dataSel && lineCtl.bank;
  assign divHiWr  = busWe && (busAddr == ADDR_DIVHI) && lineCtl.bank;
  assign lineWr   = busWe && (busAddr == ADDR_LINE);
  assign divWrite = divLoWr || divHiWr;
  assign breakOn  = lineCtl.brk;

  // data bits covered by the selected word length
  for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
    assign wordMask[i] = (4'(i) < (4'(MIN_WORD) + {2'b00, lineCtl.wordSel}));
  end

  always_comb begin
    if (lineCtl.stickSel) begin
      parNext = !lineCtl.evenSel;
    end else if (lineCtl.evenSel) begin
      parNext = ^(holdReg & wordMask);
    end else begin
      parNext = ~^(holdReg & wordMask);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCtl <= '0;
      divisor <= '0;
    end else begin
      if (lineWr) lineCtl <= lineCtl_t'(busWdata);
      if (divLoWr) divisor[BYTE_W-1:0] <= busWdata;
      if (divHiWr) divisor[DIV_W-1:BYTE_W] <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else begin
      if (holdWr) holdReg <= busWdata;
      if (holdWr) begin
        holdFull <= 1'b1;
      end else if (strobe.load) begin
        holdFull <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
      frameCfg <= '0;
    end else if (strobe.load) begin
      shiftReg <= holdReg;
      parBit   <= parNext;
      frameCfg <= '{wordSel: lineCtl.wordSel, twoStop: lineCtl.twoStop,
                    parEn: lineCtl.parEn};
    end else if (strobe.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  always_comb begin
    unique case (strobe.outSel)
      OUT_SPACE:  txOut = 1'b0;
      OUT_DATA:   txOut = shiftReg[0];
      OUT_PARITY: txOut = parBit;
      default:    txOut = 1'b1;
    endcase
    if (lineCtl.brk) txOut = 1'b0;
  end

endmodule

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
  import serial_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      holdFull,
  input  frameCfg_t cfg,
  output txStrobe_t strobe,
  output logic      frameIdle
);

  localparam int CNT_W = $clog2(2 * OVS);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_ONE  = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(OVS + OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_TWO  = CNT_W'(2 * OVS - 1);
  localparam logic [IDX_W-1:0] MIN_LAST  = IDX_W'(MIN_WORD - 1);

  txState_t         state;
  logic [CNT_W-1:0] subCnt;
  logic [CNT_W-1:0] lastSub;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             bitEnd;
  logic             loadNow;

  always_comb begin
    lastSub = LAST_ONE;
    if (state == ST_STOP && cfg.twoStop) begin
      lastSub = (cfg.wordSel == 2'b00) ? LAST_HALF : LAST_TWO;
    end
  end

  assign lastIdx   = MIN_LAST + IDX_W'(cfg.wordSel);
  assign bitEnd    = tick && (subCnt == lastSub);
  assign loadNow   = tick && holdFull &&
                     ((state == ST_IDLE) || (state == ST_STOP && bitEnd));
  assign frameIdle = (state == ST_IDLE);

  always_comb begin
    strobe.load  = loadNow;
    strobe.shift = (state == ST_DATA) && bitEnd;
    unique case (state)
      ST_START:  strobe.outSel = OUT_SPACE;
      ST_DATA:   strobe.outSel = OUT_DATA;
      ST_PARITY: strobe.outSel = OUT_PARITY;
      default:   strobe.outSel = OUT_MARK;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      subCnt <= '0;
      bitIdx <= '0;
    end else begin
      if (state != ST_IDLE && tick) begin
        subCnt <= bitEnd ? '0 : subCnt + CNT_W'(1);
      end
      unique case (state)
        ST_IDLE: begin
          if (loadNow) begin
            state  <= ST_START;
            subCnt <= '0;
          end
        end
        ST_START: begin
          if (bitEnd) begin
            state  <= ST_DATA;
            bitIdx <= '0;
          end
        end
        ST_DATA: begin
          if (bitEnd) begin
            if (bitIdx == lastIdx) begin
              state <= cfg.parEn ? ST_PARITY : ST_STOP;
            end else begin
              bitIdx <= bitIdx + IDX_W'(1);
            end
          end
        end
        ST_PARITY: begin
          if (bitEnd) state <= ST_STOP;
        end
        ST_STOP: begin
          if (bitEnd) state <= loadNow ? ST_START : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core
  import serial_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic              txOut,
  output logic              holdEmpty,
  output logic              txEmpty
);

  txStrobe_t        strobe;
  frameCfg_t        frameCfg;
  logic [DIV_W-1:0] divisor;
  logic             divWrite;
  logic             breakOn;
  logic             holdFull;
  logic             frameIdle;
  logic             tick;

  serial_tx_baud baud_i (
    .clk     (clk),
    .rstN    (rstN),
    .divisor (divisor),
    .restart (divWrite),
    .tick    (tick)
  );

  serial_tx_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strobe   (strobe),
    .holdFull (holdFull),
    .frameCfg (frameCfg),
    .divisor  (divisor),
    .divWrite (divWrite),
    .breakOn  (breakOn),
    .txOut    (txOut)
  );

  serial_tx_ctrl #(.OVS(OVS)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .holdFull  (holdFull),
    .cfg       (frameCfg),
    .strobe    (strobe),
    .frameIdle (frameIdle)
  );

  assign holdEmpty = !holdFull;
  assign txEmpty   = !holdFull && frameIdle;

endmodule

// File: rtl/serial_tx_checker.sv
module serial_tx_checker
  import serial_tx_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             txOut,
  input logic             holdEmpty,
  input logic             txEmpty,
  input logic             tick,
  input logic             loadStb,
  input logic             breakOn,
  input logic [DIV_W-1:0] divisor
);

  // empty transmitter implies empty holding register
  assert_empty_implies_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> holdEmpty);

  // idle line is high unless break is forced
  assert_idle_line_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !breakOn) |-> txOut);

  // holding empty flag only rises through a transfer
  assert_hold_sets_on_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEmpty) |-> $past(loadStb));

  // a transfer starts the frame with a low start bit
  assert_load_starts_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> !txOut);

  // transfers happen only on baud ticks
  assert_load_on_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> tick);

  // zero divisor halts the tick
  assert_no_tick_at_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (divisor == '0) |-> !tick);

  // break forces the line low
  assert_break_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    breakOn |-> !txOut);

endmodule

bind serial_tx_core serial_tx_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .txOut     (txOut),
  .holdEmpty (holdEmpty),
  .txEmpty   (txEmpty),
  .tick      (tick),
  .loadStb   (strobe.load),
  .breakOn   (breakOn),
  .divisor   (divisor)
);

// File: tb/serial_tx_core_tb.sv
module serial_tx_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic       txOut;
  logic       holdEmpty;
  logic       txEmpty;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_tx_core dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .txOut     (txOut),
    .holdEmpty (holdEmpty),
    .txEmpty   (txEmpty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr  = a;
    busWdata = d;
    busWe    = 1'b1;
    @(negedge clk);
    busWe    = 1'b0;
  endtask

  task automatic waitStart(output bit found);
    found = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (txOut == 1'b0) begin
        found = 1'b1;
        break;
      end
    end
  endtask

  function automatic int wordBits(input logic [7:0] lcr);
    return 5 + int'(lcr[1:0]);
  endfunction

  function automatic int stopTicks(input logic [7:0] lcr);
    if (!lcr[2]) return 16;
    return (lcr[1:0] == 2'b00) ? 24 : 32;
  endfunction

  function automatic int frameTicks(input logic [7:0] lcr);
    return 16 * (1 + wordBits(lcr) + int'(lcr[3])) + stopTicks(lcr);
  endfunction

  function automatic logic expParity(input logic [7:0] lcr, input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < wordBits(lcr); i++) ones += int'(d[i]);
    if (lcr[5]) return !lcr[4];
    return lcr[4] ? logic'(ones % 2) : logic'(1 - ones % 2);
  endfunction

  // sends one frame and checks every bit and the end time
  task automatic sendFrame(input logic [7:0] lcr, input logic [7:0] d, input int div);
    bit found;
    int el;
    int total;
    busWrite(2'd2, lcr);
    busWrite(2'd0, d);
    check(holdEmpty == 1'b0, "R7 holdEmpty after write", int'(holdEmpty), 0);
    waitStart(found);
    check(found, "R7 start bit seen", int'(found), 1);
    check(holdEmpty == 1'b1, "R7 holdEmpty at start", int'(holdEmpty), 1);
    el = 0;
    repeat (8 * div) @(negedge clk);
    el += 8 * div;
    check(txOut == 1'b0, "R3 start level", int'(txOut), 0);
    for (int i = 0; i < wordBits(lcr); i++) begin
      repeat (16 * div) @(negedge clk);
      el += 16 * div;
      check(txOut == d[i], "R3 data bit", int'(txOut), int'(d[i]));
    end
    if (lcr[3]) begin
      repeat (16 * div) @(negedge clk);
      el += 16 * div;
      check(txOut == expParity(lcr, d), "R4 parity bit", int'(txOut),
            int'(expParity(lcr, d)));
    end
    repeat (16 * div) @(negedge clk);
    el += 16 * div;
    check(txOut == 1'b1, "R5 stop level", int'(txOut), 1);
    total = frameTicks(lcr) * div;
    repeat (total - 1 - el) @(negedge clk);
    check(txEmpty == 1'b0, "R5 busy until last stop tick", int'(txEmpty), 0);
    @(negedge clk);
    check(txEmpty == 1'b1, "R8 txEmpty at frame end", int'(txEmpty), 1);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stimulus
    bit found;
    logic [7:0] modes [5];
    modes[0] = 8'h00; modes[1] = 8'h08; modes[2] = 8'h18;
    modes[3] = 8'h28; modes[4] = 8'h38;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txOut == 1'b1, "R1 reset line", int'(txOut), 1);
    check(holdEmpty == 1'b1, "R1 reset holdEmpty", int'(holdEmpty), 1);
    check(txEmpty == 1'b1, "R1 reset txEmpty", int'(txEmpty), 1);

    // divisor resets to zero: a written byte must wait
    busWrite(2'd0, 8'h55);
    repeat (300) @(negedge clk);
    check(txOut == 1'b1, "R6 zero divisor no start", int'(txOut), 1);
    check(holdEmpty == 1'b0, "R6 zero divisor byte waits", int'(holdEmpty), 0);
    check(txEmpty == 1'b0, "R6 zero divisor not empty", int'(txEmpty), 0);
    busWrite(2'd2, 8'h80);
    busWrite(2'd0, 8'd1);
    busWrite(2'd1, 8'd0);
    busWrite(2'd2, 8'h03);
    for (int k = 0; k < 400 && !txEmpty; k++) @(negedge clk);
    check(txEmpty == 1'b1, "R6 resumes with divisor 1", int'(txEmpty), 1);

    // bank 1: address 0 writes the divisor, not the holding register
    busWrite(2'd2, 8'h80);
    busWrite(2'd0, 8'd3);
    @(negedge clk);
    check(holdEmpty == 1'b1, "R2 bank write skips holding", int'(holdEmpty), 1);
    sendFrame(8'h03, 8'hC6, 3);
    // back to divisor 1, then an address 1 write in bank 0 is ignored
    busWrite(2'd2, 8'h80);
    busWrite(2'd0, 8'd1);
    busWrite(2'd2, 8'h03);
    busWrite(2'd1, 8'hFF);
    busWrite(2'd3, 8'hAA);
    @(negedge clk);
    check(holdEmpty == 1'b1 && txOut == 1'b1, "R2 address 3 ignored",
          int'({holdEmpty, txOut}), 3);
    sendFrame(8'h03, 8'h3A, 1);

    // format sweep: word length x stop bits x parity mode
    for (int w = 0; w < 4; w++) begin
      for (int s = 0; s < 2; s++) begin
        for (int m = 0; m < 5; m++) begin
          logic [7:0] lcr;
          logic [7:0] d;
          lcr = modes[m] | 8'(s << 2) | 8'(w);
          d = 8'hA5 ^ 8'((w * 10 + s * 5 + m) * 37);
          sendFrame(lcr, d, 1);
          sendFrame(lcr, ~d, 1);
        end
      end
    end

    // back-to-back frames, second byte queued during the first
    busWrite(2'd2, 8'h03);
    busWrite(2'd0, 8'h81);
    waitStart(found);
    check(found, "R7 first start", int'(found), 1);
    busWrite(2'd0, 8'h7E);
    check(holdEmpty == 1'b0, "R7 queued byte", int'(holdEmpty), 0);
    repeat (158) @(negedge clk);
    check(txOut == 1'b1, "R7 stop before next start", int'(txOut), 1);
    @(negedge clk);
    check(txOut == 1'b0, "R7 next start with no gap", int'(txOut), 0);
    check(holdEmpty == 1'b1 && txEmpty == 1'b0, "R7 R8 flags at second start",
          int'({holdEmpty, txEmpty}), 2);
    repeat (8 + 16) @(negedge clk);
    check(txOut == 1'b0, "R3 second frame data bit 0", int'(txOut), 0);
    repeat (160 - 24 - 1) @(negedge clk);
    check(txEmpty == 1'b0, "R8 busy in second frame", int'(txEmpty), 0);
    @(negedge clk);
    check(txEmpty == 1'b1, "R8 empty after second frame", int'(txEmpty), 1);

    // break while idle
    busWrite(2'd2, 8'h43);
    check(txOut == 1'b0, "R9 break while idle", int'(txOut), 0);
    busWrite(2'd2, 8'h03);
    check(txOut == 1'b1, "R9 break released", int'(txOut), 1);

    // break during a frame keeps the frame timing
    busWrite(2'd0, 8'hFF);
    waitStart(found);
    repeat (39) @(negedge clk);
    busWrite(2'd2, 8'h43);
    repeat (10) @(negedge clk);
    check(txOut == 1'b0, "R9 break over ones", int'(txOut), 0);
    busWrite(2'd2, 8'h03);
    repeat (8) @(negedge clk);
    check(txOut == 1'b1, "R9 data resumes after break", int'(txOut), 1);
    repeat (159 - 59) @(negedge clk);
    check(txEmpty == 1'b0, "R9 timing kept busy", int'(txEmpty), 0);
    @(negedge clk);
    check(txEmpty == 1'b1, "R9 timing kept end", int'(txEmpty), 1);

    // control change during a frame affects only later frames
    busWrite(2'd0, 8'h0F);
    waitStart(found);
    repeat (19) @(negedge clk);
    busWrite(2'd2, 8'h00);
    repeat (112 - 20) @(negedge clk);
    check(txEmpty == 1'b0, "R10 old length kept", int'(txEmpty), 0);
    repeat (159 - 112) @(negedge clk);
    check(txEmpty == 1'b0, "R10 busy to old end", int'(txEmpty), 0);
    @(negedge clk);
    check(txEmpty == 1'b1, "R10 ends at old length", int'(txEmpty), 1);
    sendFrame(8'h00, 8'h13, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule